// File: doc/BRIEF.md
# Block Transfer DMA Engine

This engine copies a run of bytes between a 16-bit host address space and a 19-bit expansion memory. Software programs the engine through a byte-wide write port. It sets a host pointer, an expansion pointer, a byte count and an address-control byte. A command write then starts the transfer. There are four operations: store (host to expansion), fetch (expansion to host), swap, and verify. Verify compares the two sides and stops at the first byte that differs.

While a transfer runs, the engine is master of both buses. It moves one byte per cycle, or one byte every two cycles in swap mode. It freezes in any cycle in which the bus-available input is low. A transfer can start as soon as the command is written. It can also be armed so that it starts on the first host write to address 0xFF00. When a transfer ends, the engine pulses `done_o`. A verify mismatch also pulses `fault_o`. If autoload was requested, the pointers and count are then reloaded from the values last written by software.

Top module: `blk_xfer_dma`

## Requirements
- R1: After reset the command byte reads 0x10, both pointers read 0, the count reads 0xFFFF, and `busy_o`, `done_o` and `fault_o` are low.
- R2: Register indices are as follows:
  - 2 and 3: host pointer, low byte then high byte.
  - 4, 5 and 6: expansion pointer, low byte upward. Index 6 uses only bits 2:0.
  - 7 and 8: count, low byte then high byte.
  - 10: address control.

  A write sets both the working value and its saved copy. Any register write made while `busy_o` is high is ignored.
- R3: The command byte is written at index 1:
  - bit 7 is execute;
  - bit 5 is autoload;
  - bit 4 is start-now;
  - bits 1:0 are the mode.

  Writing bit 7 and bit 4 both set raises `busy_o` in the next cycle.
- R4: Writing the command byte with bit 7 set and bit 4 clear arms the engine. The engine then starts in the cycle after the first host write to 0xFF00, and bit 4 reads 1 from then on. Host writes to other addresses do not start it.
- R5: Mode 00 copies host bytes to expansion memory, and mode 01 copies expansion bytes to the host. Each byte takes one cycle.
- R6: Mode 10 exchanges the two sides byte by byte. Each byte takes two cycles.
- R7: Mode 11 compares one byte per cycle and stops at the first mismatch. It then pulses `fault_o`, and each advancing pointer is left one past the failing byte.
- R8: While `ba_i` is low, the engine issues no bus access and changes no pointer. The transfer time therefore grows by exactly the number of such cycles.
- R9: Address-control bit 7 holds the host pointer and bit 6 holds the expansion pointer. An advancing host pointer wraps from 0xFFFF to 0x0000.
- R10: A count of 0 moves 65536 bytes. Without autoload, the count reads 1 after a complete transfer and the advancing pointers end one past the range.
- R11: With autoload set, the pointers and count read the last-written values after the transfer.
- R12: When a transfer ends, `busy_o` falls and `done_o` is high for the following single cycle. Command bit 7 then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register index |
| reg_wdata_i | input | 8 | Register write data |
| host_wr_i | input | 1 | Host bus write seen (trigger snoop) |
| host_addr_i | input | 16 | Address of the snooped host write |
| ba_i | input | 1 | Bus available; low stalls the engine |
| hm_req_o | output | 1 | Host bus access this cycle |
| hm_we_o | output | 1 | Host bus access is a write |
| hm_addr_o | output | 16 | Host bus address |
| hm_wdata_o | output | 8 | Host bus write data |
| hm_rdata_i | input | 8 | Host bus read data, valid in the same cycle |
| ex_en_o | output | 1 | Expansion RAM access this cycle |
| ex_we_o | output | 1 | Expansion RAM write, taken at the clock edge |
| ex_addr_o | output | 19 | Expansion RAM address |
| ex_wdata_o | output | 8 | Expansion RAM write data |
| ex_rdata_i | input | 8 | Expansion RAM read data, valid in the same cycle |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| fault_o | output | 1 | One-cycle verify-mismatch pulse |
| cmd_o | output | 8 | Command byte readback |
| host_ptr_o | output | 16 | Current host pointer |
| exp_ptr_o | output | 19 | Current expansion pointer |
| len_o | output | 16 | Current count |

## Verification
The hardest case to reach from the ports is a verify that fails partway through a transfer while bus-available drops at random. The stop pointers, the fault pulse and the cycle count must all agree in that case. To set it up, the stimulus first stores a region. It then overwrites one chosen host byte behind the engine's back, and verifies the same region with random stalls. The deferred start is also hard to reach. The stimulus arms it, shows that a write to a neighbouring address does nothing, and then fires it. A full 65536-byte transfer covers the count-zero case.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    MD_STORE  = 2'b00,
    MD_FETCH  = 2'b01,
    MD_SWAP   = 2'b10,
    MD_VERIFY = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SWAP2} seq_st_e;

  localparam int IDX_CMD  = 1;
  localparam int IDX_HOST = 2;
  localparam int IDX_EXP  = 4;
  localparam int IDX_LEN  = 7;
  localparam int IDX_CTL  = 10;

  localparam int CMD_EXEC = 7;
  localparam int CMD_AUTO = 5;
  localparam int CMD_IMM  = 4;
  localparam int CTL_HOLD_HOST = 7;
  localparam int CTL_HOLD_EXP  = 6;

  // replace one byte lane of a value
  function automatic logic [31:0] set_lane(logic [31:0] v, int lane, logic [7:0] b);
    logic [31:0] r;
    r = v;
    r[lane*8 +: 8] = b;
    return r;
  endfunction

  // advance a pointer unless it is held
  function automatic logic [31:0] bump(logic [31:0] v, logic hold);
    return hold ? v : v + 32'd1;
  endfunction

  // count down to 1 and stay there
  function automatic logic [31:0] count_down(logic [31:0] v);
    return (v == 32'd1) ? v : v - 32'd1;
  endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int HOST_AW = 16,
  parameter int EXP_AW  = 19,
  parameter int LEN_W   = 16,
  parameter logic [HOST_AW-1:0] TRIG_ADDR = HOST_AW'(32'hFF00)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we_i,
  input  logic [3:0]         reg_idx_i,
  input  logic [7:0]         reg_wdata_i,
  input  logic               host_wr_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic               busy_i,
  input  logic               step_i,
  input  logic               finish_i,
  output logic               start_o,
  output logic               last_o,
  output xfer_mode_e         mode_o,
  output logic               hold_host_o,
  output logic               hold_exp_o,
  output logic [7:0]         cmd_o,
  output logic [HOST_AW-1:0] host_ptr_o,
  output logic [EXP_AW-1:0]  exp_ptr_o,
  output logic [LEN_W-1:0]   len_o
);
  localparam int HB = (HOST_AW + 7) / 8;
  localparam int EB = (EXP_AW + 7) / 8;
  localparam int LB = (LEN_W + 7) / 8;

  logic exec_q, auto_q, imm_q, hold_h_q, hold_e_q;
  xfer_mode_e mode_q;
  logic [HOST_AW-1:0] host_q, host_sh;
  logic [EXP_AW-1:0]  exp_q, exp_sh;
  logic [LEN_W-1:0]   len_q, len_sh;

  int   ri;
  logic wr_ok, cmd_hit, trig_hit;

  always_comb begin
    ri       = int'(reg_idx_i);
    wr_ok    = reg_we_i && !busy_i;
    cmd_hit  = wr_ok && (ri == IDX_CMD);
    trig_hit = host_wr_i && (host_addr_i == TRIG_ADDR) && !busy_i && exec_q && !imm_q && !cmd_hit;
    start_o  = (cmd_hit && reg_wdata_i[CMD_EXEC] && reg_wdata_i[CMD_IMM]) || trig_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= 1'b0; auto_q <= 1'b0; imm_q <= 1'b1; mode_q <= MD_STORE;
      hold_h_q <= 1'b0; hold_e_q <= 1'b0;
      host_q <= '0; host_sh <= '0; exp_q <= '0; exp_sh <= '0;
      len_q <= '1; len_sh <= '1;
    end else begin
      if (cmd_hit) begin
        exec_q <= reg_wdata_i[CMD_EXEC];
        auto_q <= reg_wdata_i[CMD_AUTO];
        imm_q  <= reg_wdata_i[CMD_IMM];
        mode_q <= xfer_mode_e'(reg_wdata_i[1:0]);
      end else if (trig_hit) begin
        imm_q <= 1'b1;
      end else if (finish_i) begin
        exec_q <= 1'b0;
      end
      if (wr_ok && ri == IDX_CTL) begin
        hold_h_q <= reg_wdata_i[CTL_HOLD_HOST];
        hold_e_q <= reg_wdata_i[CTL_HOLD_EXP];
      end
      if (finish_i && auto_q) begin
        host_q <= host_sh; exp_q <= exp_sh; len_q <= len_sh;
      end else if (step_i) begin
        host_q <= HOST_AW'(bump(32'(host_q), hold_h_q));
        exp_q  <= EXP_AW'(bump(32'(exp_q), hold_e_q));
        len_q  <= LEN_W'(count_down(32'(len_q)));
      end
      if (wr_ok && ri >= IDX_HOST && ri < IDX_HOST + HB) begin
        host_q  <= HOST_AW'(set_lane(32'(host_q),  ri - IDX_HOST, reg_wdata_i));
        host_sh <= HOST_AW'(set_lane(32'(host_sh), ri - IDX_HOST, reg_wdata_i));
      end
      if (wr_ok && ri >= IDX_EXP && ri < IDX_EXP + EB) begin
        exp_q  <= EXP_AW'(set_lane(32'(exp_q),  ri - IDX_EXP, reg_wdata_i));
        exp_sh <= EXP_AW'(set_lane(32'(exp_sh), ri - IDX_EXP, reg_wdata_i));
      end
      if (wr_ok && ri >= IDX_LEN && ri < IDX_LEN + LB) begin
        len_q  <= LEN_W'(set_lane(32'(len_q),  ri - IDX_LEN, reg_wdata_i));
        len_sh <= LEN_W'(set_lane(32'(len_sh), ri - IDX_LEN, reg_wdata_i));
      end
    end
  end

  assign last_o      = (len_q == LEN_W'(1));
  assign mode_o      = mode_q;
  assign hold_host_o = hold_h_q;
  assign hold_exp_o  = hold_e_q;
  assign cmd_o       = {exec_q, 1'b0, auto_q, imm_q, 2'b00, mode_q};
  assign host_ptr_o  = host_q;
  assign exp_ptr_o   = exp_q;
  assign len_o       = len_q;
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       ba_i,
  input  xfer_mode_e mode_i,
  input  logic       last_i,
  input  logic [7:0] hm_rdata_i,
  input  logic [7:0] ex_rdata_i,
  output logic       busy_o,
  output logic       hm_req_o,
  output logic       hm_we_o,
  output logic [7:0] hm_wdata_o,
  output logic       ex_en_o,
  output logic       ex_we_o,
  output logic [7:0] ex_wdata_o,
  output logic       step_o,
  output logic       finish_o,
  output logic       miss_o,
  output logic       done_o,
  output logic       fault_o
);
  seq_st_e st_q;
  logic [7:0] tmp_q;
  logic done_q, fault_q;

  always_comb begin
    hm_req_o = 1'b0; hm_we_o = 1'b0; hm_wdata_o = ex_rdata_i;
    ex_en_o = 1'b0; ex_we_o = 1'b0; ex_wdata_o = hm_rdata_i;
    step_o = 1'b0; miss_o = 1'b0;
    if (ba_i) begin
      if (st_q == ST_RUN) begin
        case (mode_i)
          MD_STORE:  begin hm_req_o = 1'b1; ex_en_o = 1'b1; ex_we_o = 1'b1; step_o = 1'b1; end
          MD_FETCH:  begin hm_req_o = 1'b1; hm_we_o = 1'b1; ex_en_o = 1'b1; step_o = 1'b1; end
          MD_SWAP:   begin hm_req_o = 1'b1; end
          MD_VERIFY: begin
            hm_req_o = 1'b1; ex_en_o = 1'b1; step_o = 1'b1;
            miss_o = (hm_rdata_i != ex_rdata_i);
          end
          default: ;
        endcase
      end else if (st_q == ST_SWAP2) begin
        hm_req_o = 1'b1; hm_we_o = 1'b1;
        ex_en_o = 1'b1; ex_we_o = 1'b1; ex_wdata_o = tmp_q;
        step_o = 1'b1;
      end
    end
    finish_o = step_o && (last_i || miss_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; tmp_q <= '0; done_q <= 1'b0; fault_q <= 1'b0;
    end else begin
      done_q  <= finish_o;
      fault_q <= finish_o && miss_o;
      case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_RUN;
        ST_RUN: begin
          if (finish_o) st_q <= ST_IDLE;
          else if (ba_i && mode_i == MD_SWAP) begin
            tmp_q <= hm_rdata_i;
            st_q  <= ST_SWAP2;
          end
        end
        ST_SWAP2: if (ba_i) st_q <= finish_o ? ST_IDLE : ST_RUN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/blk_xfer_dma.sv
module blk_xfer_dma
  import dma_pkg::*;
#(
  parameter int HOST_AW = 16,
  parameter int EXP_AW  = 19,
  parameter int LEN_W   = 16,
  parameter logic [HOST_AW-1:0] TRIG_ADDR = HOST_AW'(32'hFF00)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we_i,
  input  logic [3:0]         reg_idx_i,
  input  logic [7:0]         reg_wdata_i,
  input  logic               host_wr_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic               ba_i,
  output logic               hm_req_o,
  output logic               hm_we_o,
  output logic [HOST_AW-1:0] hm_addr_o,
  output logic [7:0]         hm_wdata_o,
  input  logic [7:0]         hm_rdata_i,
  output logic               ex_en_o,
  output logic               ex_we_o,
  output logic [EXP_AW-1:0]  ex_addr_o,
  output logic [7:0]         ex_wdata_o,
  input  logic [7:0]         ex_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fault_o,
  output logic [7:0]         cmd_o,
  output logic [HOST_AW-1:0] host_ptr_o,
  output logic [EXP_AW-1:0]  exp_ptr_o,
  output logic [LEN_W-1:0]   len_o
);
  logic start_w, step_w, finish_w, miss_w, busy_w, last_w, hold_h_w, hold_e_w;
  xfer_mode_e mode_w;

  dma_regs #(.HOST_AW(HOST_AW), .EXP_AW(EXP_AW), .LEN_W(LEN_W), .TRIG_ADDR(TRIG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we_i(reg_we_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i),
    .host_wr_i(host_wr_i), .host_addr_i(host_addr_i),
    .busy_i(busy_w), .step_i(step_w), .finish_i(finish_w),
    .start_o(start_w), .last_o(last_w), .mode_o(mode_w),
    .hold_host_o(hold_h_w), .hold_exp_o(hold_e_w), .cmd_o(cmd_o),
    .host_ptr_o(host_ptr_o), .exp_ptr_o(exp_ptr_o), .len_o(len_o)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .ba_i(ba_i), .mode_i(mode_w),
    .last_i(last_w), .hm_rdata_i(hm_rdata_i), .ex_rdata_i(ex_rdata_i),
    .busy_o(busy_w), .hm_req_o(hm_req_o), .hm_we_o(hm_we_o), .hm_wdata_o(hm_wdata_o),
    .ex_en_o(ex_en_o), .ex_we_o(ex_we_o), .ex_wdata_o(ex_wdata_o),
    .step_o(step_w), .finish_o(finish_w), .miss_o(miss_w),
    .done_o(done_o), .fault_o(fault_o)
  );

  assign hm_addr_o = host_ptr_o;
  assign ex_addr_o = exp_ptr_o;
  assign busy_o    = busy_w;
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
  parameter int HOST_AW = 16,
  parameter int EXP_AW  = 19,
  parameter int LEN_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ba,
  input logic               busy,
  input logic               hm_req,
  input logic               ex_en,
  input logic               start,
  input logic               step,
  input logic               finish,
  input logic               miss,
  input logic               fault,
  input logic               hold_h,
  input logic [7:0]         cmd,
  input logic [HOST_AW-1:0] host_ptr,
  input logic [EXP_AW-1:0]  exp_ptr,
  input logic [LEN_W-1:0]   len
);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !hm_req && !ex_en);
  // R8
  ba_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ba |-> !hm_req && !ex_en);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ba |=> $stable(host_ptr) && $stable(exp_ptr) && $stable(len));
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R12
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy && !cmd[7]);
  // R9
  host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && hold_h && !finish |=> $stable(host_ptr));
  // R9
  host_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !hold_h && !finish |=> host_ptr == HOST_AW'($past(host_ptr) + 1'b1));
  // R7
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish && miss |=> fault);
endmodule

bind blk_xfer_dma dma_chk #(.HOST_AW(HOST_AW), .EXP_AW(EXP_AW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ba(ba_i), .busy(busy_w), .hm_req(hm_req_o), .ex_en(ex_en_o),
  .start(start_w), .step(step_w), .finish(finish_w), .miss(miss_w), .fault(fault_o),
  .hold_h(hold_h_w), .cmd(cmd_o), .host_ptr(host_ptr_o), .exp_ptr(exp_ptr_o), .len(len_o)
);

// File: tb/blk_xfer_dma_test.sv
`timescale 1ns/1ps
module blk_xfer_dma_test;
  localparam int MSZ = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, host_wr = 1'b0, ba = 1'b1;
  logic [3:0] reg_idx = '0;
  logic [7:0] reg_wdata = '0;
  logic [15:0] host_addr = '0;
  logic hm_req, hm_we, ex_en, ex_we, busy, done, fault;
  logic [15:0] hm_addr, host_ptr, len;
  logic [18:0] ex_addr, exp_ptr;
  logic [7:0] hm_wdata, hm_rdata, ex_wdata, ex_rdata, cmd;

  logic [7:0] hmem [MSZ];
  logic [7:0] emem [MSZ];
  logic [7:0] mh [MSZ];
  logic [7:0] me [MSZ];
  logic fill = 1'b0, poke = 1'b0;
  logic [11:0] pk_a = '0;
  logic [7:0] pk_h = '0, pk_e = '0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  blk_xfer_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
    .host_wr_i(host_wr), .host_addr_i(host_addr), .ba_i(ba),
    .hm_req_o(hm_req), .hm_we_o(hm_we), .hm_addr_o(hm_addr), .hm_wdata_o(hm_wdata),
    .hm_rdata_i(hm_rdata), .ex_en_o(ex_en), .ex_we_o(ex_we), .ex_addr_o(ex_addr),
    .ex_wdata_o(ex_wdata), .ex_rdata_i(ex_rdata), .busy_o(busy), .done_o(done),
    .fault_o(fault), .cmd_o(cmd), .host_ptr_o(host_ptr), .exp_ptr_o(exp_ptr), .len_o(len)
  );

  function automatic logic [7:0] pat_h(int i);
    return 8'(i * 29 + (i >> 4) * 3 + 5);
  endfunction
  function automatic logic [7:0] pat_e(int i);
    return 8'((i * 13) ^ 8'hA5 ^ (i >> 5));
  endfunction

  assign hm_rdata = hmem[hm_addr[11:0]];
  assign ex_rdata = emem[ex_addr[11:0]];

  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < MSZ; i++) begin hmem[i] <= pat_h(i); emem[i] <= pat_e(i); end
    end else if (poke) begin
      hmem[pk_a] <= pk_h; emem[pk_a] <= pk_e;
    end else begin
      if (hm_req && hm_we) hmem[hm_addr[11:0]] <= hm_wdata;
      if (ex_en && ex_we) emem[ex_addr[11:0]] <= ex_wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int idx, logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic host_write(logic [15:0] a);
    @(negedge clk); host_wr = 1'b1; host_addr = a;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic plant(logic [11:0] a, logic [7:0] hv);
    @(negedge clk); poke = 1'b1; pk_a = a; pk_h = hv; pk_e = me[a];
    mh[a] = hv;
    @(negedge clk); poke = 1'b0;
  endtask

  task automatic run_xfer(string tag, logic [1:0] md, logic [15:0] hs, logic [18:0] es,
                          logic [15:0] ln, bit hh, bit he, bit au, bit defer, bit poke_busy, int stall);
    logic [15:0] h; logic [18:0] e; logic [7:0] t;
    int n, bytes, cyc, st, diffs, cpb; bit fail;
    string mtag;
    wr_reg(2, hs[7:0]); wr_reg(3, hs[15:8]);
    wr_reg(4, es[7:0]); wr_reg(5, es[15:8]); wr_reg(6, {5'b0, es[18:16]});
    wr_reg(7, ln[7:0]); wr_reg(8, ln[15:8]);
    wr_reg(10, {hh, he, 6'b0});
    chk({"R2 host pointer written ", tag}, 32'(host_ptr), 32'(hs));
    chk({"R2 exp pointer written ", tag}, 32'(exp_ptr), 32'(es));
    // independent model of the transfer
    h = hs; e = es; n = (ln == 16'd0) ? 65536 : int'(ln); bytes = 0; fail = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (md)
        2'b00: me[e[11:0]] = mh[h[11:0]];
        2'b01: mh[h[11:0]] = me[e[11:0]];
        2'b10: begin t = mh[h[11:0]]; mh[h[11:0]] = me[e[11:0]]; me[e[11:0]] = t; end
        default: if (mh[h[11:0]] != me[e[11:0]]) fail = 1'b1;
      endcase
      bytes++;
      if (!hh) h = h + 16'd1;
      if (!he) e = e + 19'd1;
      if (fail) break;
    end
    cpb = (md == 2'b10) ? 2 : 1;
    if (defer) begin
      wr_reg(1, {1'b1, 1'b0, au, 1'b0, 2'b00, md});
      chk({"R4 armed stays idle ", tag}, 32'(busy), 0);
      host_write(16'hFF01);
      chk({"R4 other address ignored ", tag}, 32'(busy), 0);
      host_write(16'hFF00);
    end else begin
      wr_reg(1, {1'b1, 1'b0, au, 1'b1, 2'b00, md});
    end
    chk({"R3 R4 busy after start ", tag}, 32'(busy), 1);
    cyc = 0; st = 0;
    while (busy === 1'b1 && cyc < 140000) begin
      ba = ($urandom_range(99) >= stall);
      if (!ba) st++;
      if (poke_busy && cyc == 1) begin reg_we = 1'b1; reg_idx = 4'd2; reg_wdata = 8'hAA; end
      else reg_we = 1'b0;
      cyc++;
      @(negedge clk);
    end
    ba = 1'b1; reg_we = 1'b0;
    chk({"R8 cycle count ", tag}, 32'(cyc), 32'(bytes * cpb + st));
    chk({"R12 done pulse ", tag}, 32'(done), 1);
    chk({"R7 fault flag ", tag}, 32'(fault), 32'(fail));
    diffs = 0;
    for (int i = 0; i < MSZ; i++) begin
      if (hmem[i] !== mh[i]) diffs++;
      if (emem[i] !== me[i]) diffs++;
    end
    mtag = (md == 2'b10) ? "R6 swap memory " : (md == 2'b11) ? "R7 verify memory " : "R5 memory ";
    chk({mtag, tag}, 32'(diffs), 0);
    if (au) begin
      chk({"R11 host restored ", tag}, 32'(host_ptr), 32'(hs));
      chk({"R11 exp restored ", tag}, 32'(exp_ptr), 32'(es));
      chk({"R11 count restored ", tag}, 32'(len), 32'(ln));
    end else begin
      chk({"R9 R10 host pointer ", tag}, 32'(host_ptr), 32'(h));
      chk({"R9 R10 exp pointer ", tag}, 32'(exp_ptr), 32'(e));
      if (!fail) chk({"R10 count ends at 1 ", tag}, 32'(len), 1);
    end
    chk({"R12 command after end ", tag}, 32'(cmd), 32'({1'b0, 1'b0, au, 1'b1, 2'b00, md}));
    @(negedge clk);
    chk({"R12 done one cycle ", tag}, 32'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < MSZ; i++) begin mh[i] = pat_h(i); me[i] = pat_e(i); end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 command", 32'(cmd), 32'h10);
    chk("R1 host pointer", 32'(host_ptr), 0);
    chk("R1 exp pointer", 32'(exp_ptr), 0);
    chk("R1 count", 32'(len), 32'hFFFF);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done fault", 32'({done, fault}), 0);
    rst_n = 1'b1;
    fill = 1'b1; @(negedge clk); fill = 1'b0;

    run_xfer("store", 2'b00, 16'h0100, 19'h00200, 16'd16, 0, 0, 0, 0, 0, 0);
    run_xfer("verify match", 2'b11, 16'h0100, 19'h00200, 16'd16, 0, 0, 0, 0, 0, 20);
    run_xfer("store for miss", 2'b00, 16'h0300, 19'h00400, 16'd20, 0, 0, 0, 0, 0, 0);
    plant(12'h305, ~mh[12'h305]);
    run_xfer("verify mismatch", 2'b11, 16'h0300, 19'h00400, 16'd20, 0, 0, 0, 0, 0, 25);
    run_xfer("fetch stalled", 2'b01, 16'h0800, 19'h7F000, 16'd10, 0, 0, 0, 0, 0, 30);
    run_xfer("swap stalled", 2'b10, 16'h0A00, 19'h00A40, 16'd9, 0, 0, 0, 0, 0, 20);
    run_xfer("deferred store", 2'b00, 16'h0C00, 19'h00C80, 16'd5, 0, 0, 0, 1, 0, 0);
    run_xfer("host wrap", 2'b01, 16'hFFFC, 19'h00E00, 16'd8, 0, 0, 0, 0, 0, 10);
    run_xfer("hold host", 2'b00, 16'h0123, 19'h00D00, 16'd6, 1, 0, 0, 0, 0, 0);
    run_xfer("hold exp", 2'b01, 16'h0600, 19'h00321, 16'd6, 0, 1, 0, 0, 0, 0);
    run_xfer("hold both swap", 2'b10, 16'h0700, 19'h00700, 16'd3, 1, 1, 0, 0, 0, 0);
    run_xfer("autoload swap", 2'b10, 16'h0B00, 19'h00B40, 16'd7, 0, 0, 1, 0, 0, 25);
    run_xfer("write while busy", 2'b00, 16'h0900, 19'h00940, 16'd12, 0, 0, 0, 0, 1, 0);
    run_xfer("autoload write while busy", 2'b01, 16'h0950, 19'h00990, 16'd12, 0, 0, 1, 0, 1, 0);
    run_xfer("count zero", 2'b00, 16'h1000, 19'h01000, 16'd0, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 24; k++) begin
      logic [1:0] md; logic [15:0] hs; logic [18:0] es; logic [15:0] ln;
      md = 2'($urandom_range(3));
      hs = 16'($urandom);
      if (k % 4 == 0) hs = 16'hFFF0 | 16'($urandom_range(15));
      es = 19'($urandom);
      ln = 16'($urandom_range(24, 1));
      run_xfer("random", md, hs, es, ln, bit'($urandom_range(3) == 0), bit'($urandom_range(3) == 0),
               bit'($urandom_range(1)), bit'($urandom_range(3) == 0), 0, int'($urandom_range(40)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule